// File: doc/BRIEF.md
# Four-Phase Shared Memory Arbiter

This block divides the CPU clock into repeating groups of four phases and gives memory to the CPU in the first two phases and to the video fetch in the last two. It drives the CPU's active-low wait line, and releases it in only one phase of each group. Every memory or I/O access the CPU makes therefore lines up with that phase. A read-data holding register sits between memory and the CPU. It is loaded by the same ready signal that releases wait, so a CPU read that finishes one phase later still gets the byte memory returned in the ready phase.

In the two video phases the block puts its own video address on the memory bus and reads two successive bytes, at the address and at the address plus one. It stores them for the pixel logic. The video address then moves forward by two. A frame-start pulse reloads it from a base address. While video owns the bus, the CPU's address and write data are cut off from memory.

Top module: `vid_arbiter4`

## Requirements
- R1: After reset the block is in phase G1 with `wait_n` high. Each clock edge moves the phase on by one, in the order G1, G2, G3, G4, and back to G1.
- R2: `wait_n` is high in G1 and low in G2, G3 and G4. `latch_en` follows the same pattern.
- R3: In G1 and G2, `sel_video` is 0 and `mem_addr` equals `cpu_addr`.
- R4: In G3, `sel_video` is 1 and `mem_addr` equals the video address. The byte read then appears on `vid_byte0` from the next edge onward.
- R5: In G4, `sel_video` is 1 and `mem_addr` equals the video address plus one. The byte read then appears on `vid_byte1` from the next edge onward.
- R6: `cpu_rdata` takes the value of `mem_rdata` at the edge that ends G1. It keeps that value through G2, G3 and G4, even when memory data changes.
- R7: `mem_we` equals `cpu_wr` in G1 and G2 and is 0 in G3 and G4. In G3 and G4, `mem_wdata` is 0. In G1 and G2 it equals `cpu_wdata`.
- R8: At the edge that ends G4, the video address grows by 2.
- R9: When `frame_start` is high at an edge, the video address becomes `vid_base` at that edge. This load overrides the advance of R8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_start | input | 1 | Reloads the video address from `vid_base` |
| cpu_addr | input | AW | CPU address |
| cpu_wr | input | 1 | CPU write request |
| cpu_wdata | input | DW | CPU write data |
| vid_base | input | AW | Video start address |
| mem_rdata | input | DW | Memory read data |
| wait_n | output | 1 | Active-low wait to the CPU |
| sel_video | output | 1 | Memory address mux select, 1 selects video |
| latch_en | output | 1 | Enable of the read-data holding register |
| mem_addr | output | AW | Memory address |
| mem_we | output | 1 | Memory write enable |
| mem_wdata | output | DW | Memory write data |
| cpu_rdata | output | DW | Held read data to the CPU |
| vid_byte0 | output | DW | First video byte of the group |
| vid_byte1 | output | DW | Second video byte of the group |

## Verification
The assertions check these rules on every cycle:
- the ready phase lasts one cycle and comes back every fourth cycle;
- no write reaches memory while video owns the bus;
- video ownership lasts exactly two cycles;
- the held read data stays still outside the ready phase;
- the G4 address is one above the G3 address.

Only the bench scenarios can show the values that depend on data or history: the bytes stored for video, the advance by two across groups, the priority of a reload that lands on the G4 edge, and the byte the CPU sees after its address moves in G2.

// File: rtl/vid_arbiter4.sv
module vid_arbiter4 #(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          frame_start,
  input  logic [AW-1:0] cpu_addr,
  input  logic          cpu_wr,
  input  logic [DW-1:0] cpu_wdata,
  input  logic [AW-1:0] vid_base,
  input  logic [DW-1:0] mem_rdata,
  output logic          wait_n,
  output logic          sel_video,
  output logic          latch_en,
  output logic [AW-1:0] mem_addr,
  output logic          mem_we,
  output logic [DW-1:0] mem_wdata,
  output logic [DW-1:0] cpu_rdata,
  output logic [DW-1:0] vid_byte0,
  output logic [DW-1:0] vid_byte1
);
  localparam logic [1:0]    PH_G1 = 2'd0;
  localparam logic [1:0]    PH_G3 = 2'd2;
  localparam logic [1:0]    PH_G4 = 2'd3;
  localparam logic [AW-1:0] STEP  = AW'(2);

  logic [1:0]    ph;
  logic [AW-1:0] vaddr;
  logic          ready;

  assign ready     = (ph == PH_G1);
  assign wait_n    = ready;
  assign latch_en  = ready;
  assign sel_video = ph[1];
  assign mem_addr  = !sel_video ? cpu_addr : (ph[0] ? vaddr + AW'(1) : vaddr);
  assign mem_we    = cpu_wr & ~sel_video;
  assign mem_wdata = sel_video ? '0 : cpu_wdata;

  always_ff @(posedge clk) begin
    if (!rst_n) ph <= PH_G1;
    else        ph <= ph + 2'd1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)           vaddr <= '0;
    else if (frame_start) vaddr <= vid_base;
    else if (ph == PH_G4) vaddr <= vaddr + STEP;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vid_byte0 <= '0;
      vid_byte1 <= '0;
      cpu_rdata <= '0;
    end else begin
      if (ph == PH_G3) vid_byte0 <= mem_rdata;
      if (ph == PH_G4) vid_byte1 <= mem_rdata;
      if (ready)       cpu_rdata <= mem_rdata;
    end
  end
endmodule

// File: rtl/vid_arbiter4_chk.sv
module vid_arbiter4_chk #(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          frame_start,
  input logic          wait_n,
  input logic          sel_video,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic [DW-1:0] cpu_rdata
);
  a_r2_single_ready: assert property (@(posedge clk) disable iff (!rst_n)
    wait_n |=> !wait_n);
  a_r2_ready_period: assert property (@(posedge clk) disable iff (!rst_n)
    wait_n |=> ##3 wait_n);
  a_r3_cpu_in_ready: assert property (@(posedge clk) disable iff (!rst_n)
    wait_n |-> !sel_video);
  a_r4_video_two_cycles: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sel_video) |=> sel_video ##1 !sel_video);
  a_r5_second_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_video && $past(sel_video) && !$past(frame_start))
      |-> mem_addr == $past(mem_addr) + AW'(1));
  a_r6_hold_data: assert property (@(posedge clk) disable iff (!rst_n)
    !wait_n |=> $stable(cpu_rdata));
  a_r7_no_video_write: assert property (@(posedge clk) disable iff (!rst_n)
    sel_video |-> !mem_we);
endmodule

bind vid_arbiter4 vid_arbiter4_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .wait_n(wait_n),
  .sel_video(sel_video), .mem_we(mem_we), .mem_addr(mem_addr),
  .cpu_rdata(cpu_rdata)
);

// File: tb/vid_arbiter4_tb_top.sv
module vid_arbiter4_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 16;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          frame_start = 1'b0;
  logic [AW-1:0] cpu_addr = '0;
  logic          cpu_wr = 1'b0;
  logic [DW-1:0] cpu_wdata = '0;
  logic [AW-1:0] vid_base = '0;
  logic [DW-1:0] mem_rdata;
  logic          wait_n, sel_video, latch_en, mem_we;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata, cpu_rdata, vid_byte0, vid_byte1;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [DW-1:0] mem_f(input logic [AW-1:0] a);
    return a[7:0] ^ a[15:8] ^ 8'hA5;
  endfunction

  assign mem_rdata = mem_f(mem_addr);

  always @(posedge clk) begin
    if (!rst_n) cyc <= 0;
    else        cyc <= cyc + 1;
  end

  vid_arbiter4 #(.AW(AW), .DW(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .cpu_addr(cpu_addr),
    .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata), .vid_base(vid_base),
    .mem_rdata(mem_rdata), .wait_n(wait_n), .sel_video(sel_video),
    .latch_en(latch_en), .mem_addr(mem_addr), .mem_we(mem_we),
    .mem_wdata(mem_wdata), .cpu_rdata(cpu_rdata), .vid_byte0(vid_byte0),
    .vid_byte1(vid_byte1)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic to_phase(input int p);
    @(negedge clk);
    while ((cyc % 4) != p) @(negedge clk);
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk("R1 reset wait_n", wait_n, 1);
    chk("R1 reset sel_video", sel_video, 0);
    chk("R6 reset cpu_rdata", cpu_rdata, 0);
    chk("R4 reset vid_byte0", vid_byte0, 0);
    rst_n = 1'b1;
  endtask

  task automatic t_phases;
    logic [3:0] exp_w = 4'b0001;
    logic [3:0] exp_s = 4'b1100;
    to_phase(0);
    for (int i = 0; i < 8; i++) begin
      chk("R2 wait_n pattern", wait_n, exp_w[i%4]);
      chk("R2 latch_en pattern", latch_en, exp_w[i%4]);
      chk("R1 phase order via sel_video", sel_video, exp_s[i%4]);
      @(negedge clk);
    end
  endtask

  task automatic t_cpu_addr;
    to_phase(0);
    cpu_addr = 16'h1234;
    #1 chk("R3 G1 address", mem_addr, 16'h1234);
    @(negedge clk);
    cpu_addr = 16'h4321;
    #1 chk("R3 G2 address", mem_addr, 16'h4321);
  endtask

  task automatic t_video(input logic [AW-1:0] base);
    to_phase(0);
    vid_base = base;
    frame_start = 1'b1;
    @(negedge clk);
    frame_start = 1'b0;
    to_phase(2);
    chk("R4 G3 address", mem_addr, base);
    @(negedge clk);
    chk("R5 G4 address", mem_addr, base + 16'd1);
    @(negedge clk);
    chk("R4 first video byte", vid_byte0, mem_f(base));
    chk("R5 second video byte", vid_byte1, mem_f(base + 16'd1));
    to_phase(2);
    chk("R8 advance by two", mem_addr, base + 16'd2);
    @(negedge clk);
    chk("R8 advance second", mem_addr, base + 16'd3);
  endtask

  task automatic t_reload_g4;
    to_phase(3);
    vid_base = 16'h0A00;
    frame_start = 1'b1;
    @(negedge clk);
    frame_start = 1'b0;
    to_phase(2);
    chk("R9 reload beats advance", mem_addr, 16'h0A00);
  endtask

  task automatic t_latch;
    to_phase(0);
    cpu_addr = 16'h00F0;
    @(negedge clk);
    chk("R6 capture at end of G1", cpu_rdata, mem_f(16'h00F0));
    cpu_addr = 16'h0077;
    @(negedge clk);
    chk("R6 hold in G3", cpu_rdata, mem_f(16'h00F0));
    @(negedge clk);
    chk("R6 hold in G4", cpu_rdata, mem_f(16'h00F0));
    @(negedge clk);
    @(negedge clk);
    chk("R6 next capture", cpu_rdata, mem_f(16'h0077));
  endtask

  task automatic t_write;
    logic [3:0] exp_we = 4'b0011;
    cpu_wr = 1'b1;
    cpu_wdata = 8'h3C;
    to_phase(0);
    for (int i = 0; i < 4; i++) begin
      chk("R7 write enable", mem_we, exp_we[i]);
      chk("R7 write data", mem_wdata, exp_we[i] ? 8'h3C : 8'h00);
      @(negedge clk);
    end
    cpu_wr = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_phases();
    t_cpu_addr();
    t_video(16'h0100);
    t_video(16'h80FE);
    t_reload_g4();
    t_latch();
    t_write();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule